// File: doc/BRIEF.md
# Return and Interrupt-Return Sequencer

This block carries out the two single-word return operations of a small 8-bit processor core. One is a plain return that puts an 8-bit literal into the working register. The other is a return from interrupt. The interrupt return sets one interrupt enable again. It can also restore the working, status and bank-select registers from their shadow copies, in the same step.

In both cases the program counter is loaded from the top of the hardware return stack, and the stack is popped. The block does not write the upper or high program-counter latch registers. Each instruction takes two machine cycles of four quarter-phases each. The first cycle does the work. The second cycle is a forced no-operation, during which `flush` tells the fetch logic to discard the word it has already fetched.

A free-running phase counter gives the quarter-phases Q1 to Q4, shown as `q_phase` values 0 to 3. A new instruction word is taken only when `instr_valid` is high on the clock edge that ends a Q4 (`q_phase` = 3) while no first cycle is in progress. The first cycle of that instruction then begins with the next Q1.

Top module: `ret_seq`

## Requirements
- R1: While reset is held, `q_phase` is 0 and every strobe, `busy`, `flush` and every data output is 0.
- R2: `q_phase` counts 0, 1, 2, 3 and wraps to 0, advancing by one on each clock.
- R3: Word 0x0010 or 0x0011 is the interrupt return, with bit 0 as the fast-restore select. A word whose upper byte is 0x0C is the literal return. Any other accepted word drives no strobe, no flush and no busy.
- R4: For a literal return, `w_we` is high during Q3 of the first cycle, with `w_data` equal to the low byte of the instruction word. The status and bank-select registers are not written.
- R5: In Q4 of the first cycle of either instruction, with the stack not empty, `stack_pop` and `pc_load` are high for exactly one clock and `pc_value` equals `stack_top`.
- R6: If `stack_empty` is high at that Q4, `underflow` and `pc_load` are high, `pc_value` is 0 and `stack_pop` stays low.
- R7: For an interrupt return with bit 0 = 1, `w_we`, `status_we` and `bsr_we` are high in Q4 of the first cycle and carry the shadow values. With bit 0 = 0, none of them is asserted.
- R8: In Q4 of an interrupt return, exactly one enable strobe is set. With `prio_en` = 0 it is `ie_hi_set` (the single global enable). With `prio_en` = 1 it is `ie_hi_set` if `serv_high` = 1 and `ie_lo_set` otherwise. The literal return sets neither.
- R9: `flush` is high for all four phases of the second cycle, and `busy` is high across both cycles. A word offered at the end of the first cycle is ignored.
- R10: Every data output is 0 whenever its write or load strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-phase clock |
| rst_n | input | 1 | Active-low reset |
| instr_valid | input | 1 | Instruction word present this Q4 |
| instr | input | 16 | Instruction word |
| stack_top | input | PC_W | Top entry of the return stack |
| stack_empty | input | 1 | Return stack holds no entry |
| shadow_w | input | 8 | Shadow copy of working register |
| shadow_status | input | STATUS_W | Shadow copy of status register |
| shadow_bsr | input | BSR_W | Shadow copy of bank-select register |
| prio_en | input | 1 | Interrupt priority levels enabled |
| serv_high | input | 1 | The interrupt being serviced is high priority |
| q_phase | output | 2 | Current quarter-phase (0 = Q1) |
| busy | output | 1 | A return is in progress |
| flush | output | 1 | Discard the fetched instruction |
| stack_pop | output | 1 | Pop the return stack |
| pc_load | output | 1 | Load the program counter |
| pc_value | output | PC_W | New program counter value |
| underflow | output | 1 | A pop was attempted on an empty stack |
| w_we | output | 1 | Working register write |
| w_data | output | 8 | Working register data |
| status_we | output | 1 | Status register write |
| status_data | output | STATUS_W | Status register data |
| bsr_we | output | 1 | Bank-select register write |
| bsr_data | output | BSR_W | Bank-select register data |
| ie_hi_set | output | 1 | Set the high-priority or global enable |
| ie_lo_set | output | 1 | Set the low-priority enable |

## Verification
The stimulus mixes random words with directed ones. The random words include literal returns, both forms of the interrupt return, words one bit away from a valid opcode, and fully random words. Each phase of both cycles is compared as a whole output vector. This shows whether each write lands in the right quarter-phase and whether opcode matching is exact, for example that 0x0012 and 0x0D12 do nothing. Random values of `stack_empty`, `prio_en` and `serv_high` separate the underflow path from a normal pop, and check all three enable choices. A word offered at the end of the first cycle shows whether the flush cycle really ignores input.

// File: rtl/ret_pkg.sv
package ret_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_LIT, OP_IRET} op_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_FLUSH} seq_state_e;

  // Opcode classification: interrupt return 0x0010/0x0011, literal return 0x0Cxx
  function automatic op_kind_e classify(input logic [15:0] word);
    if (word[15:1] == 15'h0008) return OP_IRET;
    if (word[15:8] == 8'h0C)    return OP_LIT;
    return OP_NONE;
  endfunction

  // Returns {lo, hi} enable strobes for an interrupt return
  function automatic logic [1:0] ie_pick(input logic prio, input logic high);
    if (!prio) return 2'b01;
    return high ? 2'b01 : 2'b10;
  endfunction
endpackage

// File: rtl/ret_qphase.sv
module ret_qphase (
  input  logic       clk,
  input  logic       rst_n,
  output logic [1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 2'd0;
    else        q <= q + 2'd1;
  end

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (q == 2'd3) |=> (q == 2'd0)); // R2
endmodule

// File: rtl/ret_pop.sv
module ret_pop #(
  parameter int PC_W = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            empty,
  input  logic [PC_W-1:0] top,
  output logic            pop,
  output logic            load,
  output logic [PC_W-1:0] value,
  output logic            uflow
);
  assign load  = req;
  assign pop   = req && !empty;
  assign uflow = req && empty;
  assign value = pop ? top : '0;

  AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !pop); // R5
  AST_UFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |-> (value == '0) && load); // R6
endmodule

// File: rtl/ret_ie_sel.sv
module ret_ie_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic prio_en,
  input  logic serv_high,
  output logic hi_set,
  output logic lo_set
);
  import ret_pkg::*;
  logic [1:0] pick;
  assign pick   = ie_pick(prio_en, serv_high);
  assign hi_set = arm && pick[0];
  assign lo_set = arm && pick[1];

  AST_IE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_set, lo_set})); // R8
  AST_IE_LO_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    lo_set |-> prio_en && !serv_high); // R8
endmodule

// File: rtl/ret_seq.sv
module ret_seq #(
  parameter int PC_W     = 21,
  parameter int STATUS_W = 5,
  parameter int BSR_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instr_valid,
  input  logic [15:0]         instr,
  input  logic [PC_W-1:0]     stack_top,
  input  logic                stack_empty,
  input  logic [7:0]          shadow_w,
  input  logic [STATUS_W-1:0] shadow_status,
  input  logic [BSR_W-1:0]    shadow_bsr,
  input  logic                prio_en,
  input  logic                serv_high,
  output logic [1:0]          q_phase,
  output logic                busy,
  output logic                flush,
  output logic                stack_pop,
  output logic                pc_load,
  output logic [PC_W-1:0]     pc_value,
  output logic                underflow,
  output logic                w_we,
  output logic [7:0]          w_data,
  output logic                status_we,
  output logic [STATUS_W-1:0] status_data,
  output logic                bsr_we,
  output logic [BSR_W-1:0]    bsr_data,
  output logic                ie_hi_set,
  output logic                ie_lo_set
);
  import ret_pkg::*;

  localparam logic [1:0] Q3 = 2'd2;
  localparam logic [1:0] Q4 = 2'd3;

  seq_state_e state;
  op_kind_e   kind;
  logic       fast_sel;
  logic [7:0] literal;

  ret_qphase u_phase (.clk(clk), .rst_n(rst_n), .q(q_phase));

  // Named internal events
  logic cycle_end, take_word, in_exec, lit_wr, fast_wr, pop_evt, ie_arm;
  op_kind_e in_kind;

  assign cycle_end = (q_phase == Q4);
  assign in_kind   = classify(instr);
  assign take_word = cycle_end && instr_valid && (state != ST_EXEC);
  assign in_exec   = (state == ST_EXEC);
  assign lit_wr    = in_exec && (kind == OP_LIT)  && (q_phase == Q3);
  assign fast_wr   = in_exec && (kind == OP_IRET) && fast_sel && (q_phase == Q4);
  assign pop_evt   = in_exec && (q_phase == Q4);
  assign ie_arm    = in_exec && (kind == OP_IRET) && (q_phase == Q4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind     <= OP_NONE;
      fast_sel <= 1'b0;
      literal  <= 8'h00;
    end else if (cycle_end) begin
      if (in_exec) begin
        state <= ST_FLUSH;
      end else if (take_word && in_kind != OP_NONE) begin
        state    <= ST_EXEC;
        kind     <= in_kind;
        fast_sel <= instr[0];
        literal  <= instr[7:0];
      end else begin
        state <= ST_IDLE;
        kind  <= OP_NONE;
      end
    end
  end

  assign busy  = (state != ST_IDLE);
  assign flush = (state == ST_FLUSH);

  assign w_we        = lit_wr || fast_wr;
  assign w_data      = lit_wr ? literal : (fast_wr ? shadow_w : 8'h00);
  assign status_we   = fast_wr;
  assign status_data = fast_wr ? shadow_status : '0;
  assign bsr_we      = fast_wr;
  assign bsr_data    = fast_wr ? shadow_bsr : '0;

  ret_pop #(.PC_W(PC_W)) u_pop (
    .clk(clk), .rst_n(rst_n), .req(pop_evt), .empty(stack_empty),
    .top(stack_top), .pop(stack_pop), .load(pc_load),
    .value(pc_value), .uflow(underflow)
  );

  ret_ie_sel u_ie (
    .clk(clk), .rst_n(rst_n), .arm(ie_arm), .prio_en(prio_en),
    .serv_high(serv_high), .hi_set(ie_hi_set), .lo_set(ie_lo_set)
  );

  AST_POP_AT_Q4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (q_phase == Q4)); // R5
  AST_FLUSH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> flush); // R9
  AST_W_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    w_we |-> busy && !flush && (q_phase == Q3 || q_phase == Q4)); // R4
  AST_SHADOW_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    status_we |-> bsr_we && w_we && pc_load); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !w_we && !pc_load && !ie_hi_set && !ie_lo_set); // R3
endmodule

// File: tb/sim_ret_seq.sv
module sim_ret_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 21;
  localparam int SW = 5;
  localparam int BW = 4;
  localparam int VW = 2 + 1 + 8 + 1 + SW + 1 + BW + 2 + PC_W + 1 + 2 + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic [PC_W-1:0] stack_top = '0;
  logic stack_empty = 1'b0;
  logic [7:0] shadow_w = 8'h00;
  logic [SW-1:0] shadow_status = '0;
  logic [BW-1:0] shadow_bsr = '0;
  logic prio_en = 1'b0, serv_high = 1'b0;
  logic [1:0] q_phase;
  logic busy, flush, stack_pop, pc_load, underflow, w_we, status_we, bsr_we;
  logic ie_hi_set, ie_lo_set;
  logic [PC_W-1:0] pc_value;
  logic [7:0] w_data;
  logic [SW-1:0] status_data;
  logic [BW-1:0] bsr_data;

  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ret_seq #(.PC_W(PC_W), .STATUS_W(SW), .BSR_W(BW)) u0 (.*);

  function automatic logic [VW-1:0] act_vec();
    return {busy, flush, w_we, w_data, status_we, status_data, bsr_we, bsr_data,
            stack_pop, pc_load, pc_value, underflow, ie_hi_set, ie_lo_set, q_phase};
  endfunction

  // Expected output vector at phase index i (0..7) after a word is taken
  function automatic logic [VW-1:0] exp_vec(input logic [15:0] op, input int i);
    logic is_lit, is_iret, b, fl, we, swe, pop, ld, uf, hi, lo;
    logic [7:0] wd; logic [SW-1:0] sd; logic [BW-1:0] bd; logic [PC_W-1:0] pv;
    logic [1:0] q;
    is_lit  = (op[15:8] == 8'h0C);                  // R3
    is_iret = (op == 16'h0010) || (op == 16'h0011); // R3
    q = 2'(i % 4);
    b = (is_lit || is_iret) && i < 8;
    fl = b && i >= 4;
    we = 0; wd = 0; swe = 0; sd = 0; bd = 0; pop = 0; ld = 0; pv = 0; uf = 0; hi = 0; lo = 0;
    if (b && i == 2 && is_lit) begin we = 1; wd = op[7:0]; end
    if (b && i == 3) begin
      ld = 1;
      if (stack_empty) uf = 1; else begin pop = 1; pv = stack_top; end
      if (is_iret) begin
        if (op[0]) begin we = 1; wd = shadow_w; swe = 1; sd = shadow_status; bd = shadow_bsr; end
        if (!prio_en || serv_high) hi = 1; else lo = 1;
      end
    end
    return {b, fl, we, wd, swe, sd, swe, bd, pop, ld, pv, uf, hi, lo, q};
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] a, input logic [VW-1:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  function automatic string tag_for(input logic [15:0] op, input int i);
    if (!((op[15:8] == 8'h0C) || op == 16'h0010 || op == 16'h0011)) return "R3 unknown word";
    if (i >= 4) return "R9 flush cycle";
    if (i == 2 && op[15:8] == 8'h0C) return "R4 literal write";
    if (i == 3 && stack_empty) return "R6 underflow";
    if (i == 3 && op[15:8] != 8'h0C) return "R5 R7 R8 interrupt return Q4";
    if (i == 3) return "R5 pop";
    return "R10 quiet phase";
  endfunction

  task automatic run_instr(input logic [15:0] op, input bit inject);
    while (q_phase != 2'd3) @(negedge clk);
    instr = op; instr_valid = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 0) instr_valid = 1'b0;
      check(tag_for(op, i), act_vec(), exp_vec(op, i));
      if (inject && i == 3) begin instr = 16'h0C55; instr_valid = 1'b1; end
      if (inject && i == 4) instr_valid = 1'b0;
    end
    if (inject) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        check("R9 ignored word", act_vec(), exp_vec(16'h0000, i));
      end
    end
  endtask

  task automatic set_ctx(input logic emp, input logic pe, input logic sh);
    stack_top = PC_W'($urandom); stack_empty = emp;
    shadow_w = 8'($urandom); shadow_status = SW'($urandom); shadow_bsr = BW'($urandom);
    prio_en = pe; serv_high = sh;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] op;
    void'($urandom(32'h1234ABCD));
    repeat (3) @(negedge clk);
    check("R1 reset state", act_vec(), '0);
    rst_n = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check("R2 phase count", {30'd0, q_phase}, {30'd0, 2'(i % 4)});
    end
    // Directed corner cases
    set_ctx(0, 0, 0); run_instr(16'h0C00, 0);
    set_ctx(0, 0, 0); run_instr(16'h0CFF, 0);
    set_ctx(0, 0, 0); run_instr(16'h0010, 0);
    set_ctx(0, 1, 1); run_instr(16'h0011, 0);
    set_ctx(0, 1, 0); run_instr(16'h0011, 0);
    set_ctx(1, 1, 0); run_instr(16'h0010, 0);
    set_ctx(1, 0, 0); run_instr(16'h0C3C, 0);
    set_ctx(0, 0, 1); run_instr(16'h0012, 0);
    set_ctx(0, 0, 0); run_instr(16'h0D12, 0);
    set_ctx(0, 0, 0); run_instr(16'h0018, 0);
    set_ctx(0, 0, 0); run_instr(16'h0000, 0);
    set_ctx(0, 1, 1); run_instr(16'h0011, 1);
    // Constrained random mix
    for (int n = 0; n < 60; n++) begin
      case ($urandom % 5)
        0: op = {8'h0C, 8'($urandom)};
        1: op = 16'h0010 | 16'($urandom % 2);
        2: op = 16'h0010 ^ (16'h1 << ($urandom % 16));
        3: op = 16'h0C00 ^ (16'h100 << ($urandom % 8));
        default: op = 16'($urandom);
      endcase
      set_ctx(($urandom % 8) == 0, 1'($urandom), 1'($urandom));
      run_instr(op, ($urandom % 10) == 0 && op[15:8] == 8'h0C);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule